// File: doc/BRIEF.md
# OTG Interval Timeout Timer

This block measures one protocol timing interval of an On-The-Go USB port and reports when it ends. Software programs it with a single 32-bit word. The most significant control bit, bit 31, is the run flag. The low bits, 26:0 at the default width, hold the interval length in periods of the 60 MHz device clock that drives the block. A word with the run flag set loads the interval and arms the timer. If the timer is already counting, such a word starts it again from the new interval. A word with the run flag clear disarms the timer.

When the interval has elapsed, the block drives `timeout_pulse` high for exactly one clock cycle. The interrupt logic outside the block latches this pulse into bit 16 of its top-level source register. In the same cycle the readable timer word returns to zero. At all other times the read port shows the last word that was written.

Writes are always accepted in the cycle they are presented, so the write port has no valid/ready handshake and applies no back-pressure. The read port is a plain registered output.

Top module: `otg_timeout_timer`

## Requirements
- R1: After reset, `rd_data` reads zero, the timer is idle and `timeout_pulse` stays low until a start word is written.
- R2: A write stores the whole word. From the cycle after the write edge, `rd_data` equals the written value in every bit, including the bits between the count field and the run flag.
- R3: A write with bit 31 set and a count N of 1 or more in bits CNT_W-1:0 makes `timeout_pulse` high in the cycle that follows the N-th clock edge after the write edge.
- R4: A start write with a count of zero expires on the first clock edge after the write edge, the same as a count of one.
- R5: `timeout_pulse` is high for exactly one cycle per expiry. In that same cycle `rd_data` reads zero.
- R6: A start write while the timer is counting discards the remaining interval and counts the new one from that write.
- R7: A write with bit 31 clear cancels a pending expiry, so no pulse follows. The written word is still stored and read back.
- R8: A write on the same edge at which the timer would expire takes precedence. No pulse is produced, the new word is stored, and the new word's run flag decides whether counting continues.
- R9: Bits between the count field and bit 31 are stored but do not change the interval length.
- R10: While no write occurs and the timer has not expired, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz device clock; one count unit per period |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the timer word; always accepted |
| wr_data | input | DATA_W | Timer word: run flag at EN_BIT, count in CNT_W-1:0 |
| rd_data | output | DATA_W | Current timer word |
| timeout_pulse | output | 1 | One-cycle pulse when the interval ends |

## Verification
The bench builds the block with CNT_W set to 6. At that width the full-scale interval of 63 cycles, and the stored-but-ignored bits from 6 up to 30, are reachable in a short run. The other parameters keep their default values.

A behavioural reference model predicts `rd_data` and `timeout_pulse` on every cycle. Directed sequences then measure intervals of 0, 1, 5 and 63 cycles. They also cover a restart during counting, a cancel during counting, and a write landing on the expiry edge.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;
  typedef struct packed {
    logic arm;
    logic disarm;
  } tmr_cmd_t;
endpackage

// File: rtl/otg_tmr_cmd_dec.sv
module otg_tmr_cmd_dec
  import otg_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EN_BIT = 31
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output tmr_cmd_t          cmd
);
  always_comb begin
    cmd.arm    = wr_en &  wr_data[EN_BIT];
    cmd.disarm = wr_en & ~wr_data[EN_BIT];
  end
endmodule

// File: rtl/otg_tmr_count.sv
module otg_tmr_count
  import otg_tmr_pkg::*;
#(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_cmd_t         cmd,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;
  logic             run_q;

  // Last tick: the remaining count is one (or a zero load), and no write this edge
  always_comb
    expire = run_q & ~cmd.arm & ~cmd.disarm & (remain_q <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      run_q    <= 1'b0;
    end else if (cmd.arm) begin
      remain_q <= load_val;
      run_q    <= 1'b1;
    end else if (cmd.disarm) begin
      run_q    <= 1'b0;
    end else if (expire) begin
      run_q    <= 1'b0;
      remain_q <= '0;
    end else if (run_q) begin
      remain_q <= remain_q - ONE;
    end
  end
endmodule

// File: rtl/otg_tmr_value.sv
module otg_tmr_value #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  output logic [DATA_W-1:0] value_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      value_q <= '0;
    else if (wr_en)  value_q <= wr_data;
    else if (expire) value_q <= '0;
  end
endmodule

// File: rtl/otg_timeout_timer.sv
module otg_timeout_timer
  import otg_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 27,
  parameter int EN_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              timeout_pulse
);
  tmr_cmd_t cmd;
  logic     expire;
  logic     pulse_q;

  otg_tmr_cmd_dec #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  otg_tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .load_val (wr_data[CNT_W-1:0]),
    .expire   (expire)
  );

  otg_tmr_value #(.DATA_W(DATA_W)) u_val (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .expire  (expire),
    .value_q (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= expire;
  end

  assign timeout_pulse = pulse_q;
endmodule

// File: rtl/otg_timeout_timer_chk.sv
module otg_timeout_timer_chk #(
  parameter int DATA_W = 32,
  parameter int EN_BIT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              timeout_pulse
);
  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data)); // R2
  AST_PULSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> rd_data == '0); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !timeout_pulse); // R8
  AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[EN_BIT]) |=> !timeout_pulse); // R7
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (timeout_pulse || $stable(rd_data))); // R10
endmodule

bind otg_timeout_timer otg_timeout_timer_chk #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .rd_data       (rd_data),
  .timeout_pulse (timeout_pulse)
);

// File: tb/otg_timeout_timer_tb.sv
`timescale 1ns/1ps
module otg_timeout_timer_tb;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int EN_BIT = 31;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              timeout_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  otg_timeout_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT)) u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .rd_data (rd_data), .timeout_pulse (timeout_pulse)
  );

  // Behavioural reference model
  longint m_stored = 0;
  int     m_left = 0;
  bit     m_run = 1'b0;
  bit     m_pulse = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stored = 0; m_left = 0; m_run = 0; m_pulse = 0;
    end else begin
      m_pulse = 0;
      if (wr_en) begin
        m_stored = wr_data;
        m_run    = wr_data[EN_BIT];
        m_left   = int'(wr_data % (1 << CNT_W));
        if (m_left == 0) m_left = 1;
      end else if (m_run) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_run = 0; m_stored = 0; m_pulse = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R10 rd_data vs model", longint'(rd_data), m_stored);
      chk("R3/R5 timeout_pulse vs model", longint'(timeout_pulse), longint'(m_pulse));
    end
  end

  task automatic do_write(input logic [DATA_W-1:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Count negedges until the pulse; returns 0 when no pulse in `limit` cycles
  task automatic pulse_after(input int limit, output int at);
    at = 0;
    for (int j = 1; j <= limit; j++) begin
      @(negedge clk);
      if (timeout_pulse && at == 0) at = j;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int at;
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", longint'(rd_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rd_data after reset", longint'(rd_data), 0);
    chk("R1 no pulse after reset", longint'(timeout_pulse), 0);

    // R3 count 5
    do_write(32'h8000_0005);
    chk("R2 readback start word", longint'(rd_data), 64'h8000_0005);
    pulse_after(10, at);
    chk("R3 interval 5", at, 5);

    // R4 zero count
    do_write(32'h8000_0000);
    pulse_after(5, at);
    chk("R4 zero count expires next edge", at, 1);

    // count 1
    do_write(32'h8000_0001);
    pulse_after(5, at);
    chk("R3 interval 1", at, 1);
    chk("R5 value zero after expiry", longint'(rd_data), 0);

    // full scale
    do_write(32'h8000_003F);
    pulse_after(70, at);
    chk("R3 full-scale interval 63", at, 63);

    // R6 restart
    do_write(32'h8000_0014);
    repeat (5) @(negedge clk);
    do_write(32'h8000_0003);
    pulse_after(30, at);
    chk("R6 restart reloads interval", at, 3);

    // R7 cancel
    do_write(32'h8000_000A);
    repeat (4) @(negedge clk);
    do_write(32'h0000_0007);
    chk("R7 cancel word stored", longint'(rd_data), 7);
    pulse_after(20, at);
    chk("R7 no pulse after cancel", at, 0);
    chk("R10 value held while idle", longint'(rd_data), 7);

    // R8 write on expiry edge
    do_write(32'h8000_0004);
    repeat (3) @(negedge clk);
    do_write(32'h8000_0002);
    chk("R8 no pulse on colliding edge", longint'(timeout_pulse), 0);
    chk("R8 colliding word stored", longint'(rd_data), 64'h8000_0002);
    pulse_after(6, at);
    chk("R8 new interval counted", at, 2);

    // R9 upper bits ignored for counting
    do_write(32'hFF00_0043);
    chk("R9 upper bits stored", longint'(rd_data), 64'hFF00_0043);
    pulse_after(8, at);
    chk("R9 interval uses count field only", at, 3);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule